// File: doc/BRIEF.md
# Free-Running Multi-Channel Capture Timer

The block holds an up-counter that starts when reset is released and then runs without pause. It advances once every second clock cycle and rolls over to zero at its maximum value without raising any signal. Nothing but reset can stop it.

Four capture channels watch for measure events. Each channel has a selector that picks one of two sources: its own external timer input pin, which first passes through a two-stage synchronizer, or one line of an on-chip input event bus. When the selected source goes from low to high and capture is enabled, the channel copies the counter into its measure register. When its interrupt enable is also set, the channel raises a sticky request flag that stays up until a one-cycle clear pulse removes it.

Register decoding for a bus and the interrupt controller are not part of this block. Software controls are plain input ports, and the flags are plain outputs.

Top module: `capture_timer_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `count_val`, every field of `cap_val` and every bit of `irq_flag` are zero.
- R2: After reset is released, `count_val` rises by exactly one on every second rising clock edge. The first increment happens on the second edge after release. No control input affects the counter.
- R3: The counter wraps from all ones to zero. The wrap sets no interrupt flag and changes no measure register.
- R4: A capture stores the value that `count_val` showed during the cycle before the capturing edge. This is the value before any increment on that same edge.
- R5: With `src_sel[i]`=0, channel i uses `tin_pin[i]` through a two-flop synchronizer. A pin that rises before edge k is captured on edge k+2. With `src_sel[i]`=1, channel i uses `evt_bus[i]` directly, and a rise before edge k is captured on edge k.
- R6: Only a low-to-high change of the selected source causes a capture. A source held high captures once. Activity on the unselected source has no effect.
- R7: With `cap_en[i]`=0, events on channel i are ignored: its `cap_val` field and `irq_flag[i]` keep their values.
- R8: A capture with `irq_en[i]`=1 sets `irq_flag[i]` on the capturing edge. The flag stays set until cleared. With `irq_en[i]`=0 the capture still happens but the flag is left unchanged.
- R9: `irq_clr[i]` held for one cycle clears `irq_flag[i]` on the next edge. If an event that sets the flag lands on that same edge, the flag stays set.
- R10: Channels are independent. Controls and events on one channel never change another channel's measure register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tin_pin | input | NCH | External timer input pins, one per channel |
| evt_bus | input | NCH | On-chip input event lines, one per channel |
| src_sel | input | NCH | Source selector per channel: 0 = pin, 1 = event line |
| cap_en | input | NCH | Capture enable per channel |
| irq_en | input | NCH | Interrupt request enable per channel |
| irq_clr | input | NCH | One-cycle flag clear per channel |
| cap_val | output | NCH*CNT_W | Measure registers, channel i at bits [i*CNT_W +: CNT_W] |
| count_val | output | CNT_W | Live counter value |
| irq_flag | output | NCH | Sticky interrupt request flags |

## Verification
The bench builds the block with CNT_W=10 and keeps NCH=4, PRESCALE=2 and SYNC_STAGES=2. The narrow counter wraps after 2048 cycles, so rollover and capture across the rollover can be reached within a short run. The full four channels let cross-channel independence be tested. The two-stage synchronizer and the divide-by-two tick keep the pin-path and bus-path latencies exactly as the requirements state.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_BUS = 1'b1
    } src_e;

    function automatic logic pick_source(input src_e sel, input logic pin_sync,
                                         input logic bus_line);
        return (sel == SRC_BUS) ? bus_line : pin_sync;
    endfunction

endpackage

// File: rtl/ct_free_counter.sv
module ct_free_counter #(
    parameter int CNT_W    = 32,
    parameter int PRESCALE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);
    localparam int PH_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.ph == PH_LAST);
        if (tick) begin
            st_d.ph  = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.ph  = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R2: the counter moves by zero or one per edge
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

    // R2: two increments never land on adjacent edges
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESCALE > 1) && (count_o != $past(count_o)) |=> $stable(count_o));

endmodule

// File: rtl/ct_capture_chan.sv
module ct_capture_chan
    import cap_timer_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             bus_i,
    input  logic             sel_i,
    input  logic             cap_en_i,
    input  logic             irq_en_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [CNT_W-1:0]       cap;
        logic                   flag;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        src_now;
    logic        rise;
    logic        take;

    always_comb begin
        st_d    = st_q;
        src_now = pick_source(src_e'(sel_i), st_q.sync[SYNC_STAGES-1], bus_i);
        rise    = src_now & ~st_q.prev;
        take    = rise & cap_en_i;

        st_d.sync[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = src_now;

        if (take) st_d.cap = count_i;

        if (clr_i)            st_d.flag = 1'b0;
        if (take && irq_en_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;

    // R4: a capture stores the counter value seen before the edge
    a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cap_o == $past(count_i));

    // R7: without a capture the measure register holds
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cap_o));

    // R8: a set flag stays set unless cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !clr_i |=> flag_o);

    // R9: a clear with no setting event drops the flag
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !(take && irq_en_i) |=> !flag_o);

endmodule

// File: rtl/capture_timer_top.sv
module capture_timer_top #(
    parameter int CNT_W       = 32,
    parameter int NCH         = 4,
    parameter int PRESCALE    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       tin_pin,
    input  logic [NCH-1:0]       evt_bus,
    input  logic [NCH-1:0]       src_sel,
    input  logic [NCH-1:0]       cap_en,
    input  logic [NCH-1:0]       irq_en,
    input  logic [NCH-1:0]       irq_clr,
    output logic [NCH*CNT_W-1:0] cap_val,
    output logic [CNT_W-1:0]     count_val,
    output logic [NCH-1:0]       irq_flag
);
    logic [CNT_W-1:0] count_w;

    ct_free_counter #(
        .CNT_W   (CNT_W),
        .PRESCALE(PRESCALE)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .count_o(count_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ct_capture_chan #(
            .CNT_W      (CNT_W),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (tin_pin[g]),
            .bus_i   (evt_bus[g]),
            .sel_i   (src_sel[g]),
            .cap_en_i(cap_en[g]),
            .irq_en_i(irq_en[g]),
            .clr_i   (irq_clr[g]),
            .count_i (count_w),
            .cap_o   (cap_val[g*CNT_W +: CNT_W]),
            .flag_o  (irq_flag[g])
        );
    end

    assign count_val = count_w;

    // R3: rollover raises no flag on its own
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_w) == {CNT_W{1'b1}}) && (count_w == '0)
            && (irq_flag == '0) && (irq_clr == '0) |-> $stable(irq_flag));

endmodule

// File: tb/capture_timer_top_bench.sv
module capture_timer_top_bench;
    localparam int W   = 10;
    localparam int N   = 4;
    localparam int MOD = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] tin = '0, bus = '0, sel = '0, cen = '0, ien = '0, clr = '0;
    logic [N*W-1:0] cap_val;
    logic [W-1:0]   count_val;
    logic [N-1:0]   irq_flag;

    always #2.5 clk = ~clk;

    capture_timer_top #(.CNT_W(W), .NCH(N), .PRESCALE(2), .SYNC_STAGES(2)) u_capture_timer_top (
        .clk(clk), .rst_n(rst_n), .tin_pin(tin), .evt_bus(bus), .src_sel(sel),
        .cap_en(cen), .irq_en(ien), .irq_clr(clr),
        .cap_val(cap_val), .count_val(count_val), .irq_flag(irq_flag));

    int unsigned m_cnt;
    bit          m_ph;
    int unsigned m_cap [N];
    bit          m_flag [N];
    bit [1:0]    m_sync [N];
    bit          m_prev [N];
    int          vectors = 0;
    int          fails = 0;
    int          cycles = 0;
    string       cur_req = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_ph  = 0;
            for (int c = 0; c < N; c++) begin
                m_cap[c] = 0; m_flag[c] = 0; m_sync[c] = 0; m_prev[c] = 0;
            end
        end else begin
            for (int c = 0; c < N; c++) begin
                bit s, fire;
                s    = sel[c] ? bus[c] : m_sync[c][1];
                fire = s && !m_prev[c] && cen[c];
                if (fire) m_cap[c] = m_cnt;
                if (clr[c]) m_flag[c] = 0;
                if (fire && ien[c]) m_flag[c] = 1;
                m_prev[c] = s;
                m_sync[c] = {m_sync[c][0], tin[c]};
            end
            if (m_ph) m_cnt = (m_cnt + 1) % MOD;
            m_ph = !m_ph;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        vectors++;
        if (count_val !== W'(m_cnt)) begin
            fails++;
            $display("FAIL %s count_val actual %0d expected %0d", cur_req, count_val, m_cnt);
        end
        for (int c = 0; c < N; c++) begin
            if (cap_val[c*W +: W] !== W'(m_cap[c])) begin
                fails++;
                $display("FAIL %s cap[%0d] actual %0d expected %0d", cur_req, c,
                         cap_val[c*W +: W], m_cap[c]);
            end
            if (irq_flag[c] !== m_flag[c]) begin
                fails++;
                $display("FAIL %s flag[%0d] actual %0b expected %0b", cur_req, c,
                         irq_flag[c], m_flag[c]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual %0d cycles expected under 150000", cycles);
            summary();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        step(2);
        cur_req = "R2";
        clr = '1; sel = 4'b1010; step(12);
        clr = '0; sel = '0;
        cur_req = "R5";                       // pin path, ch0
        cen = '1; ien = '1;
        tin[0] = 1; step(3); tin[0] = 0; step(4);
        sel[1] = 1; bus[1] = 1; step(1); bus[1] = 0; step(3);
        cur_req = "R4";                       // capture on odd and even phases
        bus[1] = 1; step(1); bus[1] = 0; bus[2] = 1; sel[2] = 1; step(1);
        bus[2] = 0; step(3);
        cur_req = "R6";                       // held high, unselected activity
        bus[1] = 1; step(8); tin[1] = 1; step(4); tin[1] = 0; step(3); bus[1] = 0; step(2);
        tin[0] = 1; step(6); bus[0] = 1; step(3); bus[0] = 0; tin[0] = 0; step(4);
        cur_req = "R7";
        cen[3] = 0; sel[3] = 1; clr[3] = 1; step(1); clr[3] = 0;
        bus[3] = 1; step(2); bus[3] = 0; tin[3] = 1; step(4); tin[3] = 0; step(3);
        cur_req = "R8";
        cen[3] = 1; ien[3] = 0; bus[3] = 1; step(1); bus[3] = 0; step(3);
        ien[3] = 1; bus[3] = 1; step(1); bus[3] = 0; step(5);
        cur_req = "R9";
        clr[3] = 1; step(1); clr[3] = 0; step(3);
        clr[2] = 1; bus[2] = 1; step(1); clr[2] = 0; bus[2] = 0; step(3);
        clr[2] = 1; step(1); clr[2] = 0; step(2);
        cur_req = "R10";
        clr = '1; step(1); clr = '0;
        bus[1] = 1; sel[0] = 0; tin[0] = 0; step(2); bus[1] = 0; step(4);
        cur_req = "R3";                       // span the rollover
        step(2100);
        bus[2] = 1; step(1); bus[2] = 0; step(2200);
        cur_req = "R10";                      // mixed traffic
        for (int k = 0; k < 3000; k++) begin
            tin = N'($urandom); bus = N'($urandom);
            clr = N'($urandom) & N'($urandom);
            if ((k % 97) == 0) sel = N'($urandom);
            if ((k % 131) == 0) begin cen = N'($urandom); ien = N'($urandom); end
            step(1);
        end
        tin = '0; bus = '0; clr = '0;
        step(6);
        summary();
    end
endmodule